// File: doc/BRIEF.md
# Subtract Execution Slice

This block is the 8-bit subtract path of a small accumulator-style microcontroller core. It accepts one 16-bit instruction word at a time and recognises two subtract forms. In the immediate form the working register W is taken away from an 8-bit constant carried in the word, and the difference lands in W. In the register form W is taken away from a data-memory byte. A destination bit sends the difference either to W or back to that same byte. An addressing bit picks either a fixed window that spans the bottom of bank 0 and the top of the highest bank, or the bank named by a bank register.

Each accepted word runs through four internal phases: decode, operand read, compute, and write-back. After write-back the slice is ready for the next word. Five status flags are rebuilt on every subtract: carry (which means "no borrow"), digit carry, zero, overflow and negative. The slice holds W, the banked register file, the bank register and the status register. Neighbouring logic can load the bank register and preload data bytes through side ports. A combinational probe port reads any physical byte.

Top module: `sub_exec_slice`

## Requirements
- R1: After a clock edge with `rst_n` low, `w_out`, `status_out` and `bsr_out` are zero and `busy` and `retire` are low.
- R2: A word whose upper byte is 08h computes (low byte − W) mod 256 and writes the result to W.
- R3: A word whose top six bits are 010111 computes (byte − W) mod 256. Bit 9 = 0 writes the result to W and leaves the byte unchanged. Bit 9 = 1 writes it to the byte and leaves W unchanged.
- R4: With bit 8 = 0, the low byte f addresses physical byte f in bank 0 when f < 80h, and byte f in bank BANKS−1 otherwise. The physical address is bank·256 + f.
- R5: With bit 8 = 1, the bank is the low log2(BANKS) bits of the bank register, which loads from `bsr_wdata` on an edge where `bsr_we` is high.
- R6: In `status_out`, bit 0 (C) is 1 exactly when the minuend ≥ subtrahend, bit 2 (Z) is 1 exactly when the result is 00h, and bit 4 (N) equals result bit 7.
- R7: Bit 1 (DC) of `status_out` is 1 exactly when the minuend's low nibble ≥ the subtrahend's low nibble.
- R8: Bit 3 (OV) of `status_out` is 1 exactly when the operands' bit 7 values differ and the result's bit 7 differs from the minuend's.
- R9: A word is accepted on an edge with `instr_valid` high and `busy` low. `busy` is then high for four cycles, `retire` is high in the fourth of them, and W, status and the register file change on the edge that ends that fourth cycle.
- R10: `instr_valid` and `instr_word` are ignored while `busy` is high.
- R11: A word matching neither form still occupies four cycles but changes neither W, the status register nor the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| instr_word | input | 16 | Instruction word |
| instr_valid | input | 1 | Instruction word is present |
| bsr_we | input | 1 | Load the bank register |
| bsr_wdata | input | BSR_W | Bank register load value |
| fill_we | input | 1 | Preload a register-file byte |
| fill_addr | input | ADDR_W | Physical address for preload |
| fill_data | input | 8 | Preload byte |
| probe_addr | input | ADDR_W | Physical address to read out |
| probe_data | output | 8 | Byte at `probe_addr` |
| w_out | output | 8 | Working register |
| status_out | output | 5 | {N, OV, Z, DC, C} |
| bsr_out | output | BSR_W | Bank register |
| busy | output | 1 | An instruction is in its four phases |
| retire | output | 1 | Write-back phase of the current instruction |

## Verification
The bench builds the slice with its defaults: BANKS = 4 and a 4-bit bank register. With these values the access window's upper half reaches bank 3, which is distinct from bank 0. Banked accesses can reach banks 1 and 2. A bank register value of 5 shows that only the low two bits choose the bank. A reference model written with plain integers predicts W, the flags, the busy and retire timing and every memory byte, and it is compared on each clock.

// File: rtl/subx_pkg.sv
`timescale 1ns/1ps
// Shared types for the subtract execution slice.
// Assumes an 8-bit data path and a 16-bit instruction word.
package subx_pkg;
    localparam int DATA_W  = 8;
    localparam int INSTR_W = 16;
    localparam int STAT_W  = 5;

    typedef enum logic [1:0] {
        PH_DECODE = 2'd0,
        PH_READ   = 2'd1,
        PH_CALC   = 2'd2,
        PH_WRITE  = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LIT  = 2'd1,
        OP_FILE = 2'd2
    } opk_t;

    // Packed so that bit 0 is carry and bit 4 is negative.
    typedef struct packed {
        logic neg;
        logic ovf;
        logic zero;
        logic dcarry;
        logic carry;
    } flags_t;

    typedef struct packed {
        opk_t              kind;
        logic              to_file;
        logic [DATA_W-1:0] lit;
    } dec_t;
endpackage

// File: rtl/subx_decode.sv
`timescale 1ns/1ps
// Combinational decoder: classifies the instruction word and forms the
// physical register-file address from the addressing bit and bank register.
// Assumes BANKS is a power of two, at least 2, and no larger than 2**BSR_W.
module subx_decode
    import subx_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BSR_W  = 4,
    parameter int ADDR_W = 8 + $clog2(BANKS)
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [BSR_W-1:0]   bank_reg,
    output dec_t               dec,
    output logic [ADDR_W-1:0]  phys_addr
);
    localparam int BANK_W = $clog2(BANKS);
    localparam logic [BANK_W-1:0] TOP_BANK = BANK_W'(BANKS - 1);

    logic [DATA_W-1:0] fld;
    logic [BANK_W-1:0] bank_sel;

    // Opcode classification and destination bit.
    always_comb begin
        fld         = instr[7:0];
        dec.lit     = instr[7:0];
        dec.to_file = instr[9];
        if (instr[15:8] == 8'h08)
            dec.kind = OP_LIT;
        else if (instr[15:10] == 6'b010111)
            dec.kind = OP_FILE;
        else
            dec.kind = OP_NONE;
    end

    // Bank choice: access window split at 80h, or the bank register.
    always_comb begin
        if (instr[8])
            bank_sel = bank_reg[BANK_W-1:0];
        else if (fld[7])
            bank_sel = TOP_BANK;
        else
            bank_sel = '0;
    end

    assign phys_addr = {bank_sel, fld};

    generate
        if (BSR_W > BANK_W) begin : g_spare
            logic unused_bank_hi;
            assign unused_bank_hi = ^bank_reg[BSR_W-1:BANK_W];
        end
    endgenerate
endmodule

// File: rtl/subx_alu.sv
`timescale 1ns/1ps
// Combinational subtractor: result = minuend - subtrahend (mod 2**DATA_W)
// with carry as no-borrow, nibble no-borrow, zero, overflow, negative.
// Assumes DATA_W is at least 8 so a low nibble exists.
module subx_alu
    import subx_pkg::*;
(
    input  logic [DATA_W-1:0] minuend,
    input  logic [DATA_W-1:0] subtrahend,
    output logic [DATA_W-1:0] result,
    output flags_t            flags
);
    logic [DATA_W:0] wide;
    logic [4:0]      nib;

    // Full-width and nibble-wide differences with one extra borrow bit.
    always_comb begin
        wide         = {1'b0, minuend} - {1'b0, subtrahend};
        nib          = {1'b0, minuend[3:0]} - {1'b0, subtrahend[3:0]};
        result       = wide[DATA_W-1:0];
        flags.carry  = ~wide[DATA_W];
        flags.dcarry = ~nib[4];
        flags.zero   = (wide[DATA_W-1:0] == '0);
        flags.neg    = wide[DATA_W-1];
        flags.ovf    = (minuend[DATA_W-1] ^ subtrahend[DATA_W-1]) &
                       (minuend[DATA_W-1] ^ wide[DATA_W-1]);
    end
endmodule

// File: rtl/subx_regfile.sv
`timescale 1ns/1ps
// Banked data memory: one synchronous write port and two asynchronous
// read ports (operand and probe). Contents are not reset.
module subx_regfile
    import subx_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Byte write.
    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/sub_exec_slice.sv
`timescale 1ns/1ps
// Subtract execution slice: runs each accepted word through decode, read,
// compute and write phases, then updates W or a register byte and the five
// status flags. Assumes neighbours do not load the bank register or preload
// bytes while busy is high.
module sub_exec_slice
    import subx_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int BSR_W  = 4,
    parameter int ADDR_W = 8 + $clog2(BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        instr_word,
    input  logic               instr_valid,
    input  logic               bsr_we,
    input  logic [BSR_W-1:0]   bsr_wdata,
    input  logic               fill_we,
    input  logic [ADDR_W-1:0]  fill_addr,
    input  logic [7:0]         fill_data,
    input  logic [ADDR_W-1:0]  probe_addr,
    output logic [7:0]         probe_data,
    output logic [7:0]         w_out,
    output logic [4:0]         status_out,
    output logic [BSR_W-1:0]   bsr_out,
    output logic               busy,
    output logic               retire
);
    logic               busy_q;
    phase_t             phase_q;
    logic [INSTR_W-1:0] ir_q;
    dec_t               dec_c, dec_q;
    logic [ADDR_W-1:0]  addr_c, addr_q;
    logic [DATA_W-1:0]  opnd_q, wsnap_q, res_q, alu_res, rd_opnd;
    flags_t             alu_flg, flg_q, status_q;
    logic [DATA_W-1:0]  w_q;
    logic [BSR_W-1:0]   bsr_q;
    logic               rf_we;
    logic [ADDR_W-1:0]  rf_waddr;
    logic [DATA_W-1:0]  rf_wdata;

    subx_decode #(.BANKS(BANKS), .BSR_W(BSR_W), .ADDR_W(ADDR_W)) u_dec (
        .instr     (ir_q),
        .bank_reg  (bsr_q),
        .dec       (dec_c),
        .phys_addr (addr_c)
    );

    subx_alu u_alu (
        .minuend    (opnd_q),
        .subtrahend (wsnap_q),
        .result     (alu_res),
        .flags      (alu_flg)
    );

    subx_regfile #(.ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (addr_q),
        .rdata_a (rd_opnd),
        .raddr_b (probe_addr),
        .rdata_b (probe_data)
    );

    assign retire = busy_q && (phase_q == PH_WRITE);

    // Phase sequencer: idle until a word is accepted, then four phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= PH_DECODE;
        end else if (!busy_q) begin
            busy_q  <= instr_valid;
            phase_q <= PH_DECODE;
        end else if (phase_q == PH_WRITE) begin
            busy_q  <= 1'b0;
            phase_q <= PH_DECODE;
        end else begin
            phase_q <= phase_t'(phase_q + 2'd1);
        end
    end

    // Instruction capture, only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ir_q <= '0;
        else if (!busy_q && instr_valid)
            ir_q <= instr_word;
    end

    // Decode phase: hold the classification and physical address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '{kind: OP_NONE, to_file: 1'b0, lit: '0};
            addr_q <= '0;
        end else if (busy_q && phase_q == PH_DECODE) begin
            dec_q  <= dec_c;
            addr_q <= addr_c;
        end
    end

    // Read and compute phases: operand snapshot, then result and flags.
    always_ff @(posedge clk) begin
        if (busy_q && phase_q == PH_READ) begin
            opnd_q  <= (dec_q.kind == OP_LIT) ? dec_q.lit : rd_opnd;
            wsnap_q <= w_q;
        end
        if (busy_q && phase_q == PH_CALC) begin
            res_q <= alu_res;
            flg_q <= alu_flg;
        end
    end

    // Write phase: W and status update for recognised words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q      <= '0;
            status_q <= '0;
        end else if (retire && dec_q.kind != OP_NONE) begin
            status_q <= flg_q;
            if (dec_q.kind == OP_LIT || !dec_q.to_file)
                w_q <= res_q;
        end
    end

    // Bank register load from the neighbouring slice.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bsr_q <= '0;
        else if (bsr_we)
            bsr_q <= bsr_wdata;
    end

    // Register-file write source: write-back has priority over preload.
    always_comb begin
        if (retire && dec_q.kind == OP_FILE && dec_q.to_file) begin
            rf_we    = 1'b1;
            rf_waddr = addr_q;
            rf_wdata = res_q;
        end else begin
            rf_we    = fill_we;
            rf_waddr = fill_addr;
            rf_wdata = fill_data;
        end
    end

    assign w_out      = w_q;
    assign status_out = status_q;
    assign bsr_out    = bsr_q;
    assign busy       = busy_q;

    // R9: each non-final phase is followed by the next one.
    a_r9_phase_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && phase_q != PH_WRITE) |=>
            (busy_q && phase_q == phase_t'($past(phase_q) + 2'd1)));

    // R9: write phase always frees the slice.
    a_r9_retire_frees: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !busy_q);

    // R10: held instruction cannot change while busy.
    a_r10_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $stable(ir_q));

    // R11: unrecognised words leave W and status alone.
    a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && dec_q.kind == OP_NONE) |=> ($stable(w_q) && $stable(status_q)));

    // R3: write-back to a byte keeps W.
    a_r3_w_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && dec_q.kind == OP_FILE && dec_q.to_file) |=> $stable(w_q));

    // R6: a borrow never yields a zero result.
    a_r6_borrow_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !flg_q.carry) |-> (res_q != '0));

    // R6: status zero flag implies carry after a write-back.
    a_r6_zero_no_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        status_q.zero |-> status_q.carry);
endmodule

// File: tb/test_sub_exec_slice.sv
`timescale 1ns/1ps
// Bench for sub_exec_slice: an integer reference model runs beside the
// design and W, status, bank register, busy and retire are compared on
// every falling edge; register bytes are compared through the probe port.
module test_sub_exec_slice;
    localparam int BANKS  = 4;
    localparam int BSR_W  = 4;
    localparam int ADDR_W = 10;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       instr_word = '0;
    logic              instr_valid = 1'b0;
    logic              bsr_we = 1'b0;
    logic [BSR_W-1:0]  bsr_wdata = '0;
    logic              fill_we = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [7:0]        fill_data = '0;
    logic [ADDR_W-1:0] probe_addr = '0;
    logic [7:0]        probe_data, w_out;
    logic [4:0]        status_out;
    logic [BSR_W-1:0]  bsr_out;
    logic              busy, retire;

    always #10 clk = ~clk;

    sub_exec_slice #(.BANKS(BANKS), .BSR_W(BSR_W), .ADDR_W(ADDR_W)) i_sub_exec_slice (
        .clk(clk), .rst_n(rst_n), .instr_word(instr_word), .instr_valid(instr_valid),
        .bsr_we(bsr_we), .bsr_wdata(bsr_wdata), .fill_we(fill_we),
        .fill_addr(fill_addr), .fill_data(fill_data), .probe_addr(probe_addr),
        .probe_data(probe_data), .w_out(w_out), .status_out(status_out),
        .bsr_out(bsr_out), .busy(busy), .retire(retire)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference model state.
    int m_w = 0, m_st = 0, m_bank = 0, m_left = 0, m_ir = 0;
    int mem [1 << ADDR_W];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int map_addr(int ir, int bank);
        int f = ir & 255;
        if ((ir & 256) != 0)
            return (bank % BANKS) * 256 + f;
        return ((f >= 128) ? (BANKS - 1) : 0) * 256 + f;
    endfunction

    task automatic model_exec();
        int m, s, r, a, c, dc, z, ov, n;
        bit to_w;
        if (((m_ir >> 8) & 255) == 8'h08) begin
            m = m_ir & 255; a = 0; to_w = 1'b1;
        end else if (((m_ir >> 10) & 63) == 6'h17) begin
            a = map_addr(m_ir, m_bank); m = mem[a]; to_w = ((m_ir & 512) == 0);
        end else begin
            return;
        end
        s  = m_w;
        r  = (m - s) & 255;
        c  = (m >= s) ? 1 : 0;
        dc = ((m & 15) >= (s & 15)) ? 1 : 0;
        z  = (r == 0) ? 1 : 0;
        n  = (r >> 7) & 1;
        ov = ((((m ^ s) & 128) != 0) && (((m ^ r) & 128) != 0)) ? 1 : 0;
        m_st = c | (dc << 1) | (z << 2) | (ov << 3) | (n << 4);
        if (to_w) m_w = r;
        else      mem[a] = r;
    endtask

    // Reference model, cycle by cycle.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_w = 0; m_st = 0; m_bank = 0; m_left = 0;
        end else begin
            if (fill_we) mem[fill_addr] = fill_data;
            if (m_left > 0) begin
                m_left--;
                if (m_left == 0) model_exec();
            end else if (instr_valid) begin
                m_ir   = instr_word;
                m_left = 4;
            end
            if (bsr_we) m_bank = bsr_wdata;
        end
    end

    // Per-clock comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, w_out, m_w);
            chk(tag, status_out, m_st);
            chk("R5", bsr_out, m_bank);
            chk("R9", busy, (m_left > 0) ? 1 : 0);
            chk("R9", retire, (m_left == 1) ? 1 : 0);
        end
    end

    task automatic issue(int word, string t);
        @(negedge clk);
        tag = t; instr_word = word[15:0]; instr_valid = 1'b1;
        @(negedge clk);
        instr_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_w(int v, string t);
        issue(16'h0800 | ((v + m_w) & 255), t);
    endtask

    task automatic set_bank(int v);
        @(negedge clk);
        bsr_we = 1'b1; bsr_wdata = v[BSR_W-1:0];
        @(negedge clk);
        bsr_we = 1'b0;
    endtask

    task automatic fill(int a, int d);
        @(negedge clk);
        fill_we = 1'b1; fill_addr = a[ADDR_W-1:0]; fill_data = d[7:0];
        @(negedge clk);
        fill_we = 1'b0;
    endtask

    task automatic probe(int a, string req);
        @(negedge clk);
        probe_addr = a[ADDR_W-1:0];
        #2;
        chk(req, probe_data, mem[a]);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state.
        chk("R1", w_out, 0); chk("R1", status_out, 0); chk("R1", bsr_out, 0);
        chk("R1", busy, 0);  chk("R1", retire, 0);

        // R2: literal minus W into W; R6 sign cases.
        issue(16'h0802, "R2");
        issue(16'h0802, "R6");           // 02-02 -> 00, Z=1 C=1
        chk("R6", status_out, 5'b00111);
        load_w(3, "R2");
        issue(16'h0802, "R6");           // 02-03 -> FF, C=0 N=1
        chk("R6", w_out, 8'hFF);
        chk("R6", status_out, 5'b10000);
        load_w(1, "R2");
        issue(16'h0802, "R6");           // 02-01 -> 01, C=1
        chk("R6", w_out, 8'h01);

        // R7: nibble borrow and no nibble borrow.
        load_w(8'h01, "R7");
        issue(16'h0810, "R7");           // 10-01 -> 0F, DC=0
        chk("R7", status_out[1], 0);
        load_w(8'h0F, "R7");
        issue(16'h081F, "R7");           // 1F-0F -> 10, DC=1
        chk("R7", status_out[1], 1);

        // R8: signed overflow and no overflow.
        load_w(8'h01, "R8");
        issue(16'h0880, "R8");           // 80-01 -> 7F, OV=1
        chk("R8", status_out[3], 1);
        load_w(8'h7F, "R8");
        issue(16'h08FF, "R8");           // FF-7F -> 80, OV=0
        chk("R8", status_out[3], 0);

        // R3/R4: register form in the access window.
        fill(16'h020, 3);
        fill(16'h085, 8'h11);
        fill(3 * 256 + 16'h85, 8'h90);
        fill(256 + 16'h20, 8'h44);
        fill(512 + 16'h20, 8'h55);
        load_w(2, "R3");
        issue(16'h5E20, "R3");           // d=1 a=0: byte 020 <- 3-2
        probe(16'h020, "R3");
        chk("R3", w_out, 2);
        issue(16'h5C85, "R4");           // d=0 a=0: top bank byte 85
        chk("R4", w_out, 8'h8E);
        probe(16'h085, "R4");
        probe(3 * 256 + 16'h85, "R4");

        // R5: banked addressing, including a value above BANKS-1.
        load_w(4, "R5");
        set_bank(1);
        issue(16'h5F20, "R5");           // byte 120 <- 44-4
        probe(256 + 16'h20, "R5");
        chk("R5", w_out, 4);
        set_bank(5);
        issue(16'h5F20, "R5");           // low bits 01 -> bank 1 again
        probe(256 + 16'h20, "R5");
        probe(16'h020, "R5");
        set_bank(2);
        issue(16'h5D20, "R5");           // d=0: W <- 55-4
        chk("R5", w_out, 8'h51);
        probe(512 + 16'h20, "R5");

        // R11: unmatched words change nothing.
        load_w(8'h37, "R11");
        issue(16'h0937, "R11");
        issue(16'hFFFF, "R11");
        issue(16'h5B20, "R11");
        chk("R11", w_out, 8'h37);
        probe(512 + 16'h20, "R11");

        // R10: valid held high while busy with a different word.
        load_w(1, "R10");
        @(negedge clk);
        tag = "R10"; instr_word = 16'h0803; instr_valid = 1'b1;
        @(negedge clk);
        instr_word = 16'h08AA;
        repeat (4) @(negedge clk);
        instr_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R10", w_out, 2);

        finish_run();
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_run();
        end
    end
endmodule